// File: doc/BRIEF.md
# Minimum-Error Frame Pattern Generator

This block turns a two-digit decimal fraction into a 100-bit selector string for a unary frame transmitter. Each selector bit picks the frame value for one frame. A 0 selects the base digit, and a 1 selects the base digit plus one. The string is ordered so that the running average of the frame values moves toward the target as quickly as possible. As a result, only the two frame values that bracket the target ever appear.

The generator keeps a decimal (BCD) error accumulator and a sign flag. While the sign is positive it emits 0 and takes the fraction away from the accumulator. While the sign is negative it emits 1 and adds the decimal complement (100 minus the fraction). A decimal borrow or carry flips the sign. The bits come out one per cycle. They are also packed into twelve bytes and one closing nibble, ready to load into a transmitter pattern register, and a done pulse marks the end.

Top module: `frame_pattern_gen`

## Requirements
- R1: During and right after reset, busy, bit_valid, grp_valid, grp_last and done are all low.
- R2: A start pulse while idle latches p = tens_i*10 + units_i, with both digits in BCD (0 to 9). busy rises in the next cycle. The first bit_valid comes one cycle after busy rises, and exactly 100 bit_valid cycles follow, one per cycle.
- R3: The accumulator starts at 00 with the sign positive. The emitted bit equals the sign, where 1 means negative. On a positive sign, p is subtracted in decimal, and a borrow makes the sign negative. On a negative sign, 100-p is added in decimal, and a carry past 99 makes the sign positive. The first bit is therefore always 0.
- R4: Over the 100 bits of one pattern, the number of 1 bits equals p.
- R5: When p is 00, every emitted bit is 0.
- R6: After every 8th bit, grp_valid is high in the same cycle as that bit, and grp_data holds those 8 bits with the earliest in bit 7. This gives twelve full groups per pattern.
- R7: With the 100th bit, grp_valid and grp_last are both high. grp_data[3:0] holds bits 97 to 100 with the earliest in bit 3, and grp_data[7:4] is 0.
- R8: done is high for exactly one cycle, the cycle after grp_last, and busy is low in that cycle.
- R9: A start pulse while busy is ignored, and the pattern in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pattern; ignored while busy |
| tens_i | input | 4 | Tens digit of the fraction (BCD) |
| units_i | input | 4 | Units digit of the fraction (BCD) |
| busy | output | 1 | A pattern is being generated |
| bit_valid | output | 1 | bit_out holds a new selector bit |
| bit_out | output | 1 | Serial selector bit |
| grp_valid | output | 1 | grp_data holds a finished group |
| grp_data | output | 8 | Packed group, earliest bit most significant |
| grp_last | output | 1 | Marks the closing 4-bit group |
| done | output | 1 | One-cycle pulse after the pattern ends |

## Verification
Several properties are checked on every cycle:
- The accumulator always holds two valid BCD digits.
- A zero fraction never produces a 1.
- A group strobe never appears without a bit strobe.
- done is a single pulse that comes while idle.
- The latched fraction holds steady when start arrives mid-pattern.

Other behaviour can only be shown by the bench scenarios, which compare every cycle against an integer model. This covers the exact bit order, the packing of bytes and the closing nibble, the total count of 1 bits equalling the fraction, and the cycle position of each strobe for fractions of 00, 01, 10, 37, 50 and 99.

// File: rtl/frame_pattern_gen.sv
module frame_pattern_gen #(
  parameter int GRP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     tens_i,
  input  logic [3:0]     units_i,
  output logic           busy,
  output logic           bit_valid,
  output logic           bit_out,
  output logic           grp_valid,
  output logic [GRP-1:0] grp_data,
  output logic           grp_last,
  output logic           done
);
  localparam int NBITS = 100;
  localparam int CW    = $clog2(NBITS);
  localparam int REM   = NBITS % GRP;
  localparam logic [GRP-1:0] TAIL_MASK = (REM == 0) ? {GRP{1'b1}} : GRP'((1 << REM) - 1);

  function automatic logic [8:0] bcd_sub(input logic [7:0] a, input logic [7:0] b);
    logic [4:0] lo, hi;
    logic bl, bh;
    lo = {1'b0, a[3:0]} - {1'b0, b[3:0]};
    bl = lo[4];
    if (bl) lo = lo + 5'd10;
    hi = {1'b0, a[7:4]} - {1'b0, b[7:4]} - {4'b0, bl};
    bh = hi[4];
    if (bh) hi = hi + 5'd10;
    return {bh, hi[3:0], lo[3:0]};
  endfunction

  function automatic logic [8:0] bcd_add(input logic [7:0] a, input logic [7:0] b);
    logic [4:0] lo, hi;
    logic cl, ch;
    lo = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    cl = lo > 5'd9;
    if (cl) lo = lo - 5'd10;
    hi = {1'b0, a[7:4]} + {1'b0, b[7:4]} + {4'b0, cl};
    ch = hi > 5'd9;
    if (ch) hi = hi - 5'd10;
    return {ch, hi[3:0], lo[3:0]};
  endfunction

  logic [7:0]     p_q, comp_q, acc;
  logic           neg;
  logic [CW-1:0]  cnt;
  logic [GRP-2:0] sh;
  logic [8:0]     step;
  logic           at_end, grp_edge;

  assign step     = neg ? bcd_add(acc, comp_q) : bcd_sub(acc, p_q);
  assign at_end   = cnt == CW'(NBITS - 1);
  assign grp_edge = (cnt % CW'(GRP)) == CW'(GRP - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q <= '0; comp_q <= '0; acc <= '0; neg <= 1'b0; cnt <= '0; sh <= '0;
      busy <= 1'b0; bit_valid <= 1'b0; bit_out <= 1'b0;
      grp_valid <= 1'b0; grp_data <= '0; grp_last <= 1'b0; done <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      grp_valid <= 1'b0;
      grp_last  <= 1'b0;
      done      <= grp_valid && grp_last;
      if (!busy) begin
        if (start) begin
          p_q    <= {tens_i, units_i};
          comp_q <= bcd_sub(8'h00, {tens_i, units_i})[7:0];
          acc    <= '0;
          neg    <= 1'b0;
          cnt    <= '0;
          busy   <= 1'b1;
        end
      end else begin
        bit_valid <= 1'b1;
        bit_out   <= neg;
        sh        <= {sh[GRP-3:0], neg};
        acc       <= step[7:0];
        neg       <= neg ? ~step[8] : step[8];
        cnt       <= cnt + 1'b1;
        if (at_end) begin
          busy      <= 1'b0;
          grp_valid <= 1'b1;
          grp_last  <= 1'b1;
          grp_data  <= {sh, neg} & TAIL_MASK;
        end else if (grp_edge) begin
          grp_valid <= 1'b1;
          grp_data  <= {sh, neg};
        end
      end
    end
  end

  // R3
  acc_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc[3:0] <= 4'd9) && (acc[7:4] <= 4'd9));
  // R2
  digits_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (tens_i <= 4'd9) && (units_i <= 4'd9));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R5
  zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && p_q == 8'h00) |-> !bit_out);
  // R6
  grp_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> bit_valid);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(p_q));
endmodule

// File: tb/test_frame_pattern_gen.sv
module test_frame_pattern_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] tens_i = '0, units_i = '0;
  logic busy, bit_valid, bit_out, grp_valid, grp_last, done;
  logic [7:0] grp_data;
  int checks = 0, fails = 0, cycles = 0;
  bit exp_bits [100];

  always #4 clk = ~clk;

  frame_pattern_gen i_frame_pattern_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .tens_i(tens_i), .units_i(units_i),
    .busy(busy), .bit_valid(bit_valid), .bit_out(bit_out), .grp_valid(grp_valid),
    .grp_data(grp_data), .grp_last(grp_last), .done(done));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input int p);
    int acc = 0;
    bit neg = 0;
    for (int k = 0; k < 100; k++) begin
      exp_bits[k] = neg;
      if (!neg) begin
        acc = acc - p;
        if (acc < 0) begin acc += 100; neg = 1; end
      end else begin
        acc = acc + (100 - p);
        if (acc >= 100) begin acc -= 100; neg = 0; end
      end
    end
  endtask

  task automatic run(input int t, input int u, input bit poke);
    int p = t * 10 + u;
    int ones = 0;
    model(p);
    @(negedge clk);
    tens_i = 4'(t); units_i = 4'(u); start = 1'b1;
    for (int n = 1; n <= 104; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && n == 50) begin
        start = 1'b1; tens_i = 4'd5; units_i = 4'd5;
      end
      if (n == 1) chk("R2", "busy after start", busy, 1);
      chk("R2", "bit_valid", bit_valid, (n >= 2 && n <= 101) ? 1 : 0);
      if (n >= 2 && n <= 101) begin
        int idx = n - 2;
        int g = 0;
        bit last = (idx == 99);
        bit edge8 = ((idx % 8) == 7);
        ones += bit_out;
        if (poke) chk("R9", "bit during ignored start", bit_out, exp_bits[idx]);
        else if (p == 0) chk("R5", "zero fraction bit", bit_out, 0);
        else chk("R3", "bit value", bit_out, exp_bits[idx]);
        chk("R6", "grp_valid", grp_valid, (edge8 || last) ? 1 : 0);
        chk("R7", "grp_last", grp_last, last ? 1 : 0);
        if (last) begin
          for (int j = 96; j < 100; j++) g = g * 2 + exp_bits[j];
          chk("R7", "tail nibble", grp_data, g);
        end else if (edge8) begin
          for (int j = idx - 7; j <= idx; j++) g = g * 2 + exp_bits[j];
          chk("R6", "packed byte", grp_data, g);
        end
      end else begin
        chk("R6", "no grp strobe", grp_valid, 0);
      end
      chk("R8", "done", done, (n == 102) ? 1 : 0);
      if (n == 102) chk("R8", "busy at done", busy, 0);
    end
    chk("R4", "ones count", ones, p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "bit_valid in reset", bit_valid, 0);
    chk("R1", "grp_valid in reset", grp_valid, 0);
    chk("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "grp_last after reset", grp_last, 0);
    run(3, 7, 0);
    run(0, 0, 0);
    run(5, 0, 0);
    run(9, 9, 0);
    run(0, 1, 0);
    run(1, 0, 0);
    run(2, 3, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule